// File: doc/BRIEF.md
# Compute Unit Operand Latch

This block is the operand-gathering front end of a function unit. An issue pulse hands it an operation code and a per-operand skip mask. In that cycle the block takes both and becomes busy. From then on it asks the register ports only for the operands the mask leaves enabled. It stores each returned value in its own latch. When nothing is left to collect, it offers the operation and the operands to the ALU.

After the ALU takes the operands, the unit stays busy until the result has been accepted. Only then does it return to idle and accept a new issue. An active-low cancel input withdraws the ALU offer in the same cycle and sends the unit back to idle on the next edge. While the unit is idle, every operand output and the operation output read as zero, so no stale value can reach the ALU.

Top module: `cu_operand_latch`

## Requirements
- R1: An issue pulse taken while idle, with cancel not asserted, raises `busy_o` on the next clock edge, and `op_o` then shows the operation that came with the pulse. `busy_o` stays low during the issue cycle itself.
- R2: The skip mask is sampled only in the cycle an issue pulse is accepted. Changing `rd_skip_i` afterwards has no effect on requests or on readiness.
- R3: An operand whose skip bit is 1 at issue counts as already collected. It never raises its `rd_req_o` bit, and its `src_o` slice reads zero. If all bits are 1, `alu_valid_o` rises on the first busy cycle.
- R4: While busy, bit k of `rd_req_o` is high exactly while operand k is unskipped and not yet collected. A high `rd_go_i[k]` in such a cycle stores slice k of `rd_data_i`, which appears on slice k of `src_o` from the next cycle, and the request drops.
- R5: Whenever `busy_o` is low, `src_o` and `op_o` are all zeros. After reset the unit is idle.
- R6: `alu_valid_o` is high only when busy, every unskipped operand has been collected, `cancel_n_i` is high and the operands have not yet been handed over. Once high, it stays high until `alu_ready_i` is seen or cancel is asserted.
- R7: `alu_valid_o` and `alu_ready_i` high together hand the operands over: `alu_valid_o` is low from the next cycle while `busy_o` stays high. A high `res_ack_i` after the handover makes `busy_o` low on the next edge. Before the handover, `res_ack_i` is ignored.
- R8: While `cancel_n_i` is low, `alu_valid_o` is low and `alu_ready_i` and issue pulses are ignored. On the next edge the unit is idle and every collected-operand flag is cleared.
- R9: An issue pulse while `busy_o` is high is ignored: the operation, mask and collected operands are unchanged.
- R10: A high `rd_go_i[k]` for an operand that is not requesting (already collected or skipped) leaves slice k of `src_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Issue pulse |
| op_i | input | OP_W | Operation code sampled with the issue pulse |
| rd_skip_i | input | NSRC | Per-operand skip mask, 1 = operand not needed, sampled at issue |
| cancel_n_i | input | 1 | Cancel, active low |
| rd_req_o | output | NSRC | Per-operand register read request |
| rd_go_i | input | NSRC | Per-operand read response strobe |
| rd_data_i | input | NSRC*DW | Read response data, operand k in bits [k*DW +: DW] |
| alu_valid_o | output | 1 | Operands ready for the ALU |
| alu_ready_i | input | 1 | ALU takes the operands |
| res_ack_i | input | 1 | Result accepted downstream |
| busy_o | output | 1 | Unit holds an operation |
| op_o | output | OP_W | Latched operation, zero while idle |
| src_o | output | NSRC*DW | Latched operands, operand k in bits [k*DW +: DW], zero while idle |

## Verification
The bench targets the timing of the skip mask. It changes the mask right after issue. A design that kept following the live mask would drop or raise requests, and R2 catches this. The bench repeats read strobes on operands already collected and issues while busy. This exposes latches that overwrite held data or an operation code that gets replaced. It asserts cancel together with an ALU-ready and together with an issue. A design that let the handshake or the issue through would show a valid offer or a busy unit where the model shows none. A long random phase then compares every output each cycle against a behavioural model. That phase finds ordering faults, such as a result acknowledge taken before the handover or operand data left visible after the unit goes idle.

// File: rtl/cu_oplat_pkg.sv
package cu_oplat_pkg;

    // Progress of one held operation.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_GATHER = 2'd1,
        PH_HANDED = 2'd2
    } cu_phase_e;

endpackage

// File: rtl/cu_oplat_slot.sv
module cu_oplat_slot #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy_i,
    input  logic          accept_i,
    input  logic          skip_i,
    input  logic          flush_i,
    input  logic          go_i,
    input  logic [DW-1:0] data_i,
    output logic          req_o,
    output logic          vld_o,
    output logic [DW-1:0] src_o
);

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] dat;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.vld = 1'b0;
            st_d.dat = '0;
        end else if (accept_i) begin
            st_d.vld = skip_i;
            st_d.dat = '0;
        end else if (busy_i && !st_q.vld && go_i) begin
            st_d.vld = 1'b1;
            st_d.dat = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o = busy_i && !st_q.vld;
    assign vld_o = st_q.vld;
    assign src_o = busy_i ? st_q.dat : '0;

    p_skip_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && skip_i && !flush_i) |=> !req_o);

    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && go_i && !flush_i) |=> (vld_o && src_o == $past(data_i)));

    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !vld_o);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && busy_i && !flush_i && !accept_i) |=> $stable(src_o));

endmodule

// File: rtl/cu_oplat_ctrl.sv
module cu_oplat_ctrl
    import cu_oplat_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_i,
    input  logic [OP_W-1:0] op_i,
    input  logic            cancel_n_i,
    input  logic            all_vld_i,
    input  logic            alu_ready_i,
    input  logic            res_ack_i,
    output logic            busy_o,
    output logic            accept_o,
    output logic            flush_o,
    output logic            alu_valid_o,
    output logic [OP_W-1:0] op_o
);

    typedef struct packed {
        cu_phase_e       phase;
        logic [OP_W-1:0] op;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  done_w;

    always_comb begin
        st_d        = st_q;
        accept_o    = issue_i && (st_q.phase == PH_IDLE) && cancel_n_i;
        alu_valid_o = (st_q.phase == PH_GATHER) && all_vld_i && cancel_n_i;
        done_w      = (st_q.phase == PH_HANDED) && res_ack_i && cancel_n_i;
        flush_o     = !cancel_n_i || done_w;

        if (!cancel_n_i) begin
            st_d.phase = PH_IDLE;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: begin
                    if (issue_i) begin
                        st_d.phase = PH_GATHER;
                        st_d.op    = op_i;
                    end
                end
                PH_GATHER: begin
                    if (alu_valid_o && alu_ready_i) begin
                        st_d.phase = PH_HANDED;
                    end
                end
                PH_HANDED: begin
                    if (res_ack_i) begin
                        st_d.phase = PH_IDLE;
                    end
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, op: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.phase != PH_IDLE);
    assign op_o   = busy_o ? st_q.op : '0;

    p_busy_after_issue_r1: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> busy_o);

    p_handoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_valid_o && alu_ready_i) |=> (busy_o && !alu_valid_o));

    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cancel_n_i && !res_ack_i) |=> busy_o);

    p_cancel_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cancel_n_i |=> !busy_o);

    p_issue_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && issue_i && !flush_o) |=> $stable(op_o));

endmodule

// File: rtl/cu_operand_latch.sv
module cu_operand_latch #(
    parameter int NSRC = 3,
    parameter int DW   = 64,
    parameter int OP_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_i,
    input  logic [OP_W-1:0]    op_i,
    input  logic [NSRC-1:0]    rd_skip_i,
    input  logic               cancel_n_i,
    output logic [NSRC-1:0]    rd_req_o,
    input  logic [NSRC-1:0]    rd_go_i,
    input  logic [NSRC*DW-1:0] rd_data_i,
    output logic               alu_valid_o,
    input  logic               alu_ready_i,
    input  logic               res_ack_i,
    output logic               busy_o,
    output logic [OP_W-1:0]    op_o,
    output logic [NSRC*DW-1:0] src_o
);

    localparam int SRC_BITS = NSRC * DW;

    logic [NSRC-1:0] vld_w;
    logic            accept_w;
    logic            flush_w;

    cu_oplat_ctrl #(
        .OP_W(OP_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_i    (issue_i),
        .op_i       (op_i),
        .cancel_n_i (cancel_n_i),
        .all_vld_i  (&vld_w),
        .alu_ready_i(alu_ready_i),
        .res_ack_i  (res_ack_i),
        .busy_o     (busy_o),
        .accept_o   (accept_w),
        .flush_o    (flush_w),
        .alu_valid_o(alu_valid_o),
        .op_o       (op_o)
    );

    for (genvar k = 0; k < NSRC; k++) begin : g_slot
        cu_oplat_slot #(
            .DW(DW)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .busy_i  (busy_o),
            .accept_i(accept_w),
            .skip_i  (rd_skip_i[k]),
            .flush_i (flush_w),
            .go_i    (rd_go_i[k]),
            .data_i  (rd_data_i[k*DW +: DW]),
            .req_o   (rd_req_o[k]),
            .vld_o   (vld_w[k]),
            .src_o   (src_o[k*DW +: DW])
        );
    end

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (src_o == {SRC_BITS{1'b0}} && op_o == '0));

    p_valid_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        alu_valid_o |-> (&vld_w && rd_req_o == '0));

endmodule

// File: tb/cu_operand_latch_bench.sv
`timescale 1ns/1ps
module cu_operand_latch_bench;
    localparam int NS = 3;
    localparam int DW = 64;
    localparam int OW = 8;
    localparam int SB = NS * DW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          issue_i;
    logic [OW-1:0] op_i;
    logic [NS-1:0] rd_skip_i;
    logic          cancel_n_i;
    logic [NS-1:0] rd_req_o;
    logic [NS-1:0] rd_go_i;
    logic [SB-1:0] rd_data_i;
    logic          alu_valid_o;
    logic          alu_ready_i;
    logic          res_ack_i;
    logic          busy_o;
    logic [OW-1:0] op_o;
    logic [SB-1:0] src_o;

    always #4 clk = ~clk;

    cu_operand_latch u_cu_operand_latch (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
        .rd_skip_i(rd_skip_i), .cancel_n_i(cancel_n_i), .rd_req_o(rd_req_o),
        .rd_go_i(rd_go_i), .rd_data_i(rd_data_i), .alu_valid_o(alu_valid_o),
        .alu_ready_i(alu_ready_i), .res_ack_i(res_ack_i), .busy_o(busy_o),
        .op_o(op_o), .src_o(src_o)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit fin    = 0;

    // behavioural reference
    bit            m_busy, m_sent;
    logic [OW-1:0] m_op;
    bit            m_vld [NS];
    logic [DW-1:0] m_dat [NS];

    task automatic chk(input string tag, input logic [SB-1:0] act, input logic [SB-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit m_all();
        bit a = 1;
        for (int k = 0; k < NS; k++) a &= m_vld[k];
        return a;
    endfunction

    function automatic bit m_valid();
        return m_busy && !m_sent && m_all() && cancel_n_i;
    endfunction

    task automatic look();
        logic [NS-1:0] er;
        logic [SB-1:0] es;
        #1;
        er = '0;
        es = '0;
        for (int k = 0; k < NS; k++) begin
            er[k] = m_busy && !m_vld[k];
            if (m_busy) es[k*DW +: DW] = m_dat[k];
        end
        chk("R1 model busy", SB'(busy_o), SB'(m_busy));
        chk("R4 model request", SB'(rd_req_o), SB'(er));
        chk("R6 model alu_valid", SB'(alu_valid_o), SB'(m_valid()));
        chk("R5 model src", src_o, es);
        chk("R9 model op", SB'(op_o), SB'(m_busy ? m_op : '0));
    endtask

    task automatic m_clear();
        m_busy = 0;
        m_sent = 0;
        for (int k = 0; k < NS; k++) begin
            m_vld[k] = 0;
            m_dat[k] = '0;
        end
    endtask

    task automatic tick();
        bit v;
        @(posedge clk);
        v = m_valid();
        if (!rst_n || !cancel_n_i) begin
            m_clear();
        end else if (m_busy && m_sent && res_ack_i) begin
            m_clear();
        end else if (!m_busy && issue_i) begin
            m_busy = 1;
            m_op   = op_i;
            for (int k = 0; k < NS; k++) begin
                m_vld[k] = rd_skip_i[k];
                m_dat[k] = '0;
            end
        end else if (m_busy) begin
            for (int k = 0; k < NS; k++) begin
                if (!m_vld[k] && rd_go_i[k]) begin
                    m_vld[k] = 1;
                    m_dat[k] = rd_data_i[k*DW +: DW];
                end
            end
            if (v && alu_ready_i) m_sent = 1;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        issue_i     = 0;
        op_i        = '0;
        rd_skip_i   = '0;
        cancel_n_i  = 1;
        rd_go_i     = '0;
        rd_data_i   = '0;
        alu_ready_i = 0;
        res_ack_i   = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1..all actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    localparam logic [DW-1:0] VA = 64'hA5A5_0000_1111_2222;
    localparam logic [DW-1:0] VB = 64'hDEAD_BEEF_0000_0001;
    localparam logic [DW-1:0] VC = 64'h0123_4567_89AB_CDEF;
    localparam logic [DW-1:0] VD = 64'hFFFF_0000_FFFF_0000;
    localparam logic [DW-1:0] VE = 64'h0000_0000_0000_0E0E;

    initial begin
        rst_n = 0;
        m_op  = '0;
        m_clear();
        idle();
        repeat (3) tick();
        rst_n = 1;
        look();
        chk("R5 reset busy", SB'(busy_o), '0);
        chk("R5 reset src", src_o, '0);
        chk("R5 reset req", SB'(rd_req_o), '0);
        tick();

        // R1 issue, all operands needed
        issue_i = 1; op_i = 8'h5A; rd_skip_i = 3'b000;
        look();
        chk("R1 busy low in issue cycle", SB'(busy_o), '0);
        tick();
        idle(); rd_skip_i = 3'b111;
        look();
        chk("R1 busy after issue", SB'(busy_o), 1);
        chk("R1 op shown", SB'(op_o), SB'(8'h5A));
        chk("R2 late mask ignored, req", SB'(rd_req_o), SB'(3'b111));
        tick();

        // R4 capture operand 0
        idle(); rd_go_i = 3'b001; rd_data_i[0 +: DW] = VA;
        look(); tick();
        idle(); rd_go_i = 3'b001; rd_data_i[0 +: DW] = VB;
        issue_i = 1; op_i = 8'h33;
        look();
        chk("R4 req drops after capture", SB'(rd_req_o), SB'(3'b110));
        chk("R4 captured slice", SB'(src_o[0 +: DW]), SB'(VA));
        tick();
        idle();
        look();
        chk("R10 stray strobe ignored", SB'(src_o[0 +: DW]), SB'(VA));
        chk("R9 issue while busy ignored", SB'(op_o), SB'(8'h5A));
        rd_go_i = 3'b110; rd_data_i[DW +: DW] = VC; rd_data_i[2*DW +: DW] = VD;
        look(); tick();
        idle();
        look();
        chk("R6 valid after all captured", SB'(alu_valid_o), 1);
        chk("R4 all slices", src_o, {VD, VC, VA});
        tick();
        idle();
        look();
        chk("R6 valid held without ready", SB'(alu_valid_o), 1);
        alu_ready_i = 1;
        look(); tick();
        idle();
        look();
        chk("R7 valid drops after handover", SB'(alu_valid_o), 0);
        chk("R7 busy held after handover", SB'(busy_o), 1);
        res_ack_i = 1;
        look(); tick();
        idle();
        look();
        chk("R7 idle after result ack", SB'(busy_o), 0);
        chk("R5 src zero when idle", src_o, '0);
        tick();

        // R3 partial mask
        issue_i = 1; op_i = 8'h77; rd_skip_i = 3'b101;
        look(); tick();
        idle();
        look();
        chk("R3 skipped no request", SB'(rd_req_o), SB'(3'b010));
        chk("R3 skipped slices zero", src_o, '0);
        rd_go_i = 3'b010; rd_data_i[DW +: DW] = VE;
        look(); tick();
        idle();
        look();
        chk("R6 valid with skips", SB'(alu_valid_o), 1);
        cancel_n_i = 0; alu_ready_i = 1;
        look();
        chk("R8 valid suppressed by cancel", SB'(alu_valid_o), 0);
        tick();
        idle();
        look();
        chk("R8 idle after cancel", SB'(busy_o), 0);
        tick();
        issue_i = 1; op_i = 8'h11;
        look(); tick();
        idle();
        look();
        chk("R8 flags cleared by cancel", SB'(rd_req_o), SB'(3'b111));
        cancel_n_i = 0;
        look(); tick();
        idle(); cancel_n_i = 0; issue_i = 1; op_i = 8'h44;
        look(); tick();
        idle();
        look();
        chk("R8 issue ignored under cancel", SB'(busy_o), 0);

        // R3 all skipped
        issue_i = 1; op_i = 8'h22; rd_skip_i = 3'b111;
        look(); tick();
        idle();
        look();
        chk("R3 all skipped valid at once", SB'(alu_valid_o), 1);
        chk("R3 all skipped no requests", SB'(rd_req_o), '0);
        alu_ready_i = 1;
        look(); tick();
        idle(); res_ack_i = 1;
        look(); tick();
        idle();
        look();
        chk("R7 idle after ack", SB'(busy_o), 0);

        // R7 ack before handover ignored
        issue_i = 1; op_i = 8'h66; rd_skip_i = 3'b110;
        look(); tick();
        idle(); res_ack_i = 1;
        look(); tick();
        idle();
        look();
        chk("R7 early ack ignored", SB'(busy_o), 1);
        tick();

        // random phase, full model comparison every cycle
        for (int i = 0; i < 2000; i++) begin
            issue_i     = ($urandom % 4) == 0;
            op_i        = OW'($urandom);
            rd_skip_i   = NS'($urandom);
            cancel_n_i  = ($urandom % 20) != 0;
            rd_go_i     = NS'($urandom);
            for (int k = 0; k < NS; k++)
                rd_data_i[k*DW +: DW] = {$urandom, $urandom};
            alu_ready_i = $urandom % 2;
            res_ack_i   = ($urandom % 3) == 0;
            look();
            tick();
        end

        fin = 1;
        summary();
        $finish;
    end
endmodule